// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the 32-bit control and status word for a floating-point pipeline. Software reaches it through a whole-word read and write port. Execution logic reaches single bits through narrower update ports: one for the eight condition codes, with a read-back of the addressed code, and one each for exception flags, trap enables and exception causes.

The block drives the rounding mode and the flush-to-zero control straight to the arithmetic units. It also keeps a two-deep history of condition code 0. Each instruction issue strobe moves that history one step, so branch logic can see the value that was in force when the previous instruction began.

The condition codes are not packed together. Code 0 sits at bit 23. Codes 1 to 7 sit at bits 25 to 31. Bit 24 between them is the flush-to-zero control.

Top module: `fpcsr_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no update, the word reads 0, rounding mode is 0, flush-to-zero is 0, and both cc0 history outputs are 0.
- R2: A full-word write stores the written data with bits 22:18 forced to 0. The word read port shows the stored value in the cycle after the write edge.
- R3: `round_mode` equals word bits 1:0 (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf). `flush_zero` equals word bit 24.
- R4: Condition code index 0 maps to word bit 23 and index N (1..7) maps to bit 24+N. `cc_rd_val` returns the bit selected by `cc_idx`.
- R5: A condition-code write changes only its mapped bit. Every other bit, bit 24 included, is unchanged.
- R6: A flag update with index 0..4 writes word bit 2+index. An index of 5, 6 or 7 leaves the word unchanged.
- R7: An enable update with index 0..4 writes word bit 7+index. An index of 5, 6 or 7 leaves the word unchanged.
- R8: A cause update with index 0..5 writes word bit 12+index. An index of 6 or 7 leaves the word unchanged.
- R9: When a full-word write and any single-bit update share a cycle, the word takes the full-word data only.
- R10: On an edge with `issue` high, `cc0_prev` takes the old `cc0_cur`, and `cc0_cur` takes word bit 23 as it stood before that edge. Without `issue`, both hold their values.
- R11: Word bits 22:18 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Full-word write strobe |
| sw_wr_data | input | 32 | Full-word write data |
| sw_rd_data | output | 32 | Current register word |
| cc_wr_en | input | 1 | Condition-code write strobe |
| cc_idx | input | 3 | Condition-code index, used for both write and read |
| cc_wr_val | input | 1 | Condition-code write value |
| cc_rd_val | output | 1 | Value of the indexed condition code |
| flag_wr_en | input | 1 | Sticky flag update strobe |
| flag_idx | input | 3 | Flag index |
| flag_val | input | 1 | Flag value |
| enb_wr_en | input | 1 | Trap enable update strobe |
| enb_idx | input | 3 | Enable index |
| enb_val | input | 1 | Enable value |
| cause_wr_en | input | 1 | Cause update strobe |
| cause_idx | input | 3 | Cause index |
| cause_val | input | 1 | Cause value |
| issue | input | 1 | Instruction issue strobe that advances the cc0 history |
| round_mode | output | 2 | Rounding mode field |
| flush_zero | output | 1 | Flush-to-zero control |
| cc0_cur | output | 1 | cc0 sampled at the latest issue |
| cc0_prev | output | 1 | cc0 sampled at the issue before that |

## Verification
The bench targets the hole at bit 24. A design that mapped the codes contiguously would put code 1 onto the flush-to-zero bit and toggle `flush_zero`. It also drives out-of-range indices (flag 5, enable 7, cause 6). A range check that was off by one would set a neighbouring field's bit or wrap onto a low bit.

It issues in the same cycle as a full-word write that clears cc0. A history that sampled the new word instead of the old one would show 0 where 1 is expected. It also collides full-word writes with bit updates, where wrong priority leaves a stray bit set.

A behavioural model tracks all of this on every clock through long stretches of random traffic.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int unsigned CSR_W     = 32;
  localparam int unsigned IDX_W     = 3;
  localparam int unsigned RM_LSB    = 0;
  localparam int unsigned RM_W      = 2;
  localparam int unsigned FLAG_LSB  = 2;
  localparam int unsigned N_FLAG    = 5;
  localparam int unsigned ENB_LSB   = FLAG_LSB + N_FLAG;
  localparam int unsigned CAUSE_LSB = ENB_LSB + N_FLAG;
  localparam int unsigned N_CAUSE   = N_FLAG + 1;
  localparam int unsigned RSV_LSB   = CAUSE_LSB + N_CAUSE;
  localparam int unsigned CC0_POS   = 23;
  localparam int unsigned RSV_W     = CC0_POS - RSV_LSB;
  localparam int unsigned FZ_POS    = CC0_POS + 1;
  localparam int unsigned N_CC      = 8;
  localparam int unsigned CC_SKIP   = 1;
  localparam logic [CSR_W-1:0] RSV_MASK = ((CSR_W'(1) << RSV_W) - CSR_W'(1)) << RSV_LSB;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
    logic             val;
  } bit_upd_t;
endpackage

// File: rtl/fpcsr_bit_sel.sv
module fpcsr_bit_sel #(
  parameter int unsigned W     = 32,
  parameter int unsigned LSB   = 0,
  parameter int unsigned COUNT = 1,
  parameter int unsigned SKIP  = 0,
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     mask
);
  // one-hot position of idx inside a field; indices >= COUNT select nothing
  always_comb begin
    mask = '0;
    for (int i = 0; i < int'(COUNT); i++) begin
      if (int'(idx) == i) mask[int'(LSB) + i + ((i > 0) ? int'(SKIP) : 0)] = 1'b1;
    end
  end
endmodule

// File: rtl/fpcsr_cc0_hist.sv
module fpcsr_cc0_hist (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic cc0_now,
  output logic cc0_prev,
  output logic cc0_cur
);
  logic prev_d, cur_d;

  always_comb begin
    prev_d = cc0_cur;
    cur_d  = cc0_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc0_prev <= 1'b0;
      cc0_cur  <= 1'b0;
    end else if (issue) begin
      cc0_prev <= prev_d;
      cc0_cur  <= cur_d;
    end
  end

  // R10: the history shifts on issue and holds otherwise
  a_r10_shift: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (cc0_prev == $past(cc0_cur)) && (cc0_cur == $past(cc0_now)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(cc0_prev) && $stable(cc0_cur));
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [CSR_W-1:0] sw_wr_data,
  output logic [CSR_W-1:0] sw_rd_data,
  input  logic             cc_wr_en,
  input  logic [IDX_W-1:0] cc_idx,
  input  logic             cc_wr_val,
  output logic             cc_rd_val,
  input  logic             flag_wr_en,
  input  logic [IDX_W-1:0] flag_idx,
  input  logic             flag_val,
  input  logic             enb_wr_en,
  input  logic [IDX_W-1:0] enb_idx,
  input  logic             enb_val,
  input  logic             cause_wr_en,
  input  logic [IDX_W-1:0] cause_idx,
  input  logic             cause_val,
  input  logic             issue,
  output logic [RM_W-1:0]  round_mode,
  output logic             flush_zero,
  output logic             cc0_prev,
  output logic             cc0_cur
);
  localparam int unsigned N_FIELD = 4;

  bit_upd_t         upd [N_FIELD];
  logic [CSR_W-1:0] sel [N_FIELD];
  logic [CSR_W-1:0] csr_q, csr_d;
  logic             csr_we;

  always_comb begin
    upd[0] = '{en: cc_wr_en,    idx: cc_idx,    val: cc_wr_val};
    upd[1] = '{en: flag_wr_en,  idx: flag_idx,  val: flag_val};
    upd[2] = '{en: enb_wr_en,   idx: enb_idx,   val: enb_val};
    upd[3] = '{en: cause_wr_en, idx: cause_idx, val: cause_val};
  end

  localparam int unsigned F_LSB   [N_FIELD] = '{CC0_POS, FLAG_LSB, ENB_LSB, CAUSE_LSB};
  localparam int unsigned F_COUNT [N_FIELD] = '{N_CC, N_FLAG, N_FLAG, N_CAUSE};
  localparam int unsigned F_SKIP  [N_FIELD] = '{CC_SKIP, 0, 0, 0};

  genvar f;
  generate
    for (f = 0; f < N_FIELD; f++) begin : g_field
      fpcsr_bit_sel #(
        .W(CSR_W), .LSB(F_LSB[f]), .COUNT(F_COUNT[f]), .SKIP(F_SKIP[f]), .IDX_W(IDX_W)
      ) u_sel (
        .idx  (upd[f].idx),
        .mask (sel[f])
      );
    end
  endgenerate

  // next state: the full-word write wins over every single-bit update
  always_comb begin
    csr_d = csr_q;
    if (sw_wr_en) begin
      csr_d = sw_wr_data & ~RSV_MASK;
    end else begin
      for (int k = 0; k < int'(N_FIELD); k++) begin
        if (upd[k].en) csr_d = (csr_d & ~sel[k]) | (sel[k] & {CSR_W{upd[k].val}});
      end
    end
  end

  assign csr_we = sw_wr_en | cc_wr_en | flag_wr_en | enb_wr_en | cause_wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= '0;
    else if (csr_we) csr_q <= csr_d;
  end

  fpcsr_cc0_hist u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .cc0_now  (csr_q[CC0_POS]),
    .cc0_prev (cc0_prev),
    .cc0_cur  (cc0_cur)
  );

  assign sw_rd_data = csr_q;
  assign cc_rd_val  = |(csr_q & sel[0]);
  assign round_mode = csr_q[RM_LSB +: RM_W];
  assign flush_zero = csr_q[FZ_POS];

  // R11: reserved span never becomes non-zero
  a_r11_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_data & RSV_MASK) == '0);
  // R9: full-word data lands regardless of concurrent bit updates
  a_r9_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> sw_rd_data == ($past(sw_wr_data) & ~RSV_MASK));
  // R5: a lone condition-code write flips at most one bit and never bit 24
  a_r5_cc_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_wr_en && !sw_wr_en && !flag_wr_en && !enb_wr_en && !cause_wr_en)
    |=> ($countones(sw_rd_data ^ $past(sw_rd_data)) <= 1) && $stable(flush_zero));
  // R6: out-of-range flag index is ignored
  a_r6_flag_oob: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && (int'(flag_idx) >= int'(N_FLAG)) && !sw_wr_en && !cc_wr_en && !enb_wr_en && !cause_wr_en)
    |=> $stable(sw_rd_data));
  // R8: out-of-range cause index is ignored
  a_r8_cause_oob: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_wr_en && (int'(cause_idx) >= int'(N_CAUSE)) && !sw_wr_en && !cc_wr_en && !flag_wr_en && !enb_wr_en)
    |=> $stable(sw_rd_data));
endmodule

// File: tb/fpcsr_unit_bench.sv
`timescale 1ns/1ps
module fpcsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en;
  logic [31:0] sw_wr_data;
  logic [31:0] sw_rd_data;
  logic        cc_wr_en, cc_wr_val, cc_rd_val;
  logic [2:0]  cc_idx, flag_idx, enb_idx, cause_idx;
  logic        flag_wr_en, flag_val, enb_wr_en, enb_val, cause_wr_en, cause_val;
  logic        issue;
  logic [1:0]  round_mode;
  logic        flush_zero, cc0_prev, cc0_cur;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_csr;
  logic        m_prev, m_cur;

  always #2 clk = ~clk;

  fpcsr_unit u_fpcsr_unit (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .sw_rd_data(sw_rd_data),
    .cc_wr_en(cc_wr_en), .cc_idx(cc_idx), .cc_wr_val(cc_wr_val), .cc_rd_val(cc_rd_val),
    .flag_wr_en(flag_wr_en), .flag_idx(flag_idx), .flag_val(flag_val),
    .enb_wr_en(enb_wr_en), .enb_idx(enb_idx), .enb_val(enb_val),
    .cause_wr_en(cause_wr_en), .cause_idx(cause_idx), .cause_val(cause_val),
    .issue(issue), .round_mode(round_mode), .flush_zero(flush_zero),
    .cc0_prev(cc0_prev), .cc0_cur(cc0_cur)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int cc_bit(input logic [2:0] i);
    return (i == 3'd0) ? 23 : 24 + int'(i);
  endfunction

  // behavioural model of one clock edge, using the inputs held before it
  task automatic model_step();
    if (issue) begin
      m_prev = m_cur;
      m_cur  = m_csr[23];
    end
    if (sw_wr_en) m_csr = sw_wr_data & 32'hFF83FFFF;
    else begin
      if (cc_wr_en) m_csr[cc_bit(cc_idx)] = cc_wr_val;
      if (flag_wr_en && flag_idx < 3'd5) m_csr[2 + int'(flag_idx)] = flag_val;
      if (enb_wr_en && enb_idx < 3'd5) m_csr[7 + int'(enb_idx)] = enb_val;
      if (cause_wr_en && cause_idx < 3'd6) m_csr[12 + int'(cause_idx)] = cause_val;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    model_step();
    chk("R2 word", sw_rd_data, m_csr);
    chk("R3 round_mode", 32'(round_mode), 32'(m_csr[1:0]));
    chk("R3 flush_zero", 32'(flush_zero), 32'(m_csr[24]));
    chk("R4 cc_rd_val", 32'(cc_rd_val), 32'(m_csr[cc_bit(cc_idx)]));
    chk("R10 cc0_cur", 32'(cc0_cur), 32'(m_cur));
    chk("R10 cc0_prev", 32'(cc0_prev), 32'(m_prev));
  endtask

  task automatic idle();
    sw_wr_en = 0; cc_wr_en = 0; flag_wr_en = 0; enb_wr_en = 0; cause_wr_en = 0; issue = 0;
  endtask

  task automatic word_wr(input logic [31:0] d);
    idle(); sw_wr_en = 1; sw_wr_data = d; cycle(); idle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    sw_wr_data = '0; cc_idx = '0; cc_wr_val = 0;
    flag_idx = '0; flag_val = 0; enb_idx = '0; enb_val = 0; cause_idx = '0; cause_val = 0;
    m_csr = '0; m_prev = 0; m_cur = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", sw_rd_data, 32'h0);
    chk("R1 reset hist", {30'h0, cc0_prev, cc0_cur}, 32'h0);
    chk("R1 reset rm/fz", {29'h0, round_mode, flush_zero}, 32'h0);
    rst_n = 1;
    cycle();
    chk("R1 after release", sw_rd_data, 32'h0);

    // R10 history: cc0 set, then issue
    word_wr(32'h0080_0000);
    issue = 1; cycle(); idle();
    chk("R10 cur after first issue", {30'h0, cc0_prev, cc0_cur}, 32'h1);
    issue = 1; sw_wr_en = 1; sw_wr_data = 32'h0; cycle(); idle();
    chk("R10 issue samples old cc0", {30'h0, cc0_prev, cc0_cur}, 32'h3);
    issue = 1; cycle(); idle();
    chk("R10 shift in zero", {30'h0, cc0_prev, cc0_cur}, 32'h2);
    cycle();
    chk("R10 hold without issue", {30'h0, cc0_prev, cc0_cur}, 32'h2);

    // R2/R11/R3 all ones
    word_wr(32'hFFFF_FFFF);
    chk("R2 R11 masked write", sw_rd_data, 32'hFF83_FFFF);
    chk("R3 rm toward -inf", 32'(round_mode), 32'd3);
    chk("R3 fz set", 32'(flush_zero), 32'd1);
    word_wr(32'h0000_0001);
    chk("R3 rm toward zero", 32'(round_mode), 32'd1);

    // R4/R5 condition codes around the hole
    word_wr(32'h0);
    cc_wr_en = 1; cc_idx = 3'd1; cc_wr_val = 1; cycle(); idle();
    chk("R4 cc1 at bit 25", sw_rd_data, 32'h0200_0000);
    chk("R5 fz untouched", 32'(flush_zero), 32'd0);
    cc_wr_en = 1; cc_idx = 3'd0; cc_wr_val = 1; cycle(); idle();
    chk("R4 cc0 at bit 23", sw_rd_data, 32'h0280_0000);
    cc_wr_en = 1; cc_idx = 3'd7; cc_wr_val = 1; cycle(); idle();
    chk("R4 cc7 read back", 32'(cc_rd_val), 32'd1);
    cc_idx = 3'd6; cycle();
    chk("R4 cc6 read clear", 32'(cc_rd_val), 32'd0);
    cc_wr_en = 1; cc_idx = 3'd1; cc_wr_val = 0; cycle(); idle();
    chk("R5 clear only cc1", sw_rd_data, 32'h8080_0000);

    // R6/R7/R8 index ranges
    word_wr(32'h0);
    flag_wr_en = 1; flag_idx = 3'd5; flag_val = 1; cycle(); idle();
    chk("R6 flag idx5 ignored", sw_rd_data, 32'h0);
    flag_wr_en = 1; flag_idx = 3'd4; flag_val = 1; cycle(); idle();
    chk("R6 flag idx4 bit6", sw_rd_data, 32'h0000_0040);
    enb_wr_en = 1; enb_idx = 3'd7; enb_val = 1; cycle(); idle();
    chk("R7 enable idx7 ignored", sw_rd_data, 32'h0000_0040);
    enb_wr_en = 1; enb_idx = 3'd0; enb_val = 1; cycle(); idle();
    chk("R7 enable idx0 bit7", sw_rd_data, 32'h0000_00C0);
    cause_wr_en = 1; cause_idx = 3'd6; cause_val = 1; cycle(); idle();
    chk("R8 cause idx6 ignored", sw_rd_data, 32'h0000_00C0);
    cause_wr_en = 1; cause_idx = 3'd5; cause_val = 1; cycle(); idle();
    chk("R8 cause idx5 bit17", sw_rd_data, 32'h0002_00C0);

    // R9 priority
    sw_wr_en = 1; sw_wr_data = 32'h0000_0002;
    cc_wr_en = 1; cc_idx = 3'd3; cc_wr_val = 1;
    flag_wr_en = 1; flag_idx = 3'd0; flag_val = 1;
    cause_wr_en = 1; cause_idx = 3'd0; cause_val = 1;
    cycle(); idle();
    chk("R9 full-word wins", sw_rd_data, 32'h0000_0002);
    chk("R3 rm toward +inf", 32'(round_mode), 32'd2);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      sw_wr_en    = ($urandom % 10) == 0;
      sw_wr_data  = $urandom;
      cc_wr_en    = $urandom % 2; cc_idx = 3'($urandom); cc_wr_val = 1'($urandom);
      flag_wr_en  = $urandom % 2; flag_idx = 3'($urandom); flag_val = 1'($urandom);
      enb_wr_en   = $urandom % 2; enb_idx = 3'($urandom); enb_val = 1'($urandom);
      cause_wr_en = $urandom % 2; cause_idx = 3'($urandom); cause_val = 1'($urandom);
      issue       = $urandom % 2;
      cycle();
    end
    idle();
    cycle();

    done = 1;
    summary();
    $finish;
  end
endmodule